// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns a single burst command into the stream of per-beat addresses that a data mover or memory slave walks through. A command carries a start address, a beat count coded as count minus one, a size code giving 2^size bytes per beat, and a stepping mode. The block then presents one beat address per cycle on a valid/ready output. The final beat carries a last marker, after which the block takes the next command.

Three stepping modes are offered. Fixed repeats one address, for FIFO-style targets. Incrementing steps through memory and aligns a misaligned start down to the beat size. Wrapping steps like incrementing but folds back inside a window whose size is the total burst size and which is aligned to that size. A wrapping command with an unsupported length or a misaligned start, or a command with the reserved mode code, is rejected with a one-cycle error pulse and produces no beats.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, cmd_ready is 1, beat_valid is 0 and cmd_err is 0.
- R2: With mode code 0 (fixed), every beat address equals the start address exactly as given, with no alignment.
- R3: With mode code 1 (incrementing), the first beat address is the start address with its low `size` bits cleared, and each later beat adds 2^size.
- R4: With mode code 2 (wrapping), addresses step by 2^size and stay inside the window of (len+1)*2^size bytes aligned to that size, returning to the window base after its top; a 4-beat, 4-byte burst from 0x108 yields 0x108, 0x10C, 0x100, 0x104.
- R5: A command with length field L yields exactly L+1 beats, L from 0 to 255, and beat_last is 1 on the final beat only.
- R6: While beat_valid is 1 and beat_ready is 0, beat_valid stays 1 and beat_addr and beat_last stay unchanged in the next cycle.
- R7: cmd_ready is 0 while a burst is being emitted and returns to 1 in the cycle after the last beat is accepted.
- R8: A wrapping command whose length field is not 1, 3, 7 or 15, or whose start address is not a multiple of 2^size, or any command with mode code 3, is accepted, raises cmd_err for exactly the next cycle and produces no beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | AW | Start address |
| cmd_len | input | LW | Beats minus one |
| cmd_size | input | SW | Log2 of bytes per beat |
| cmd_mode | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| cmd_err | output | 1 | One-cycle pulse after an illegal command is taken |
| beat_valid | output | 1 | Beat address presented |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | AW | Address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |

## Verification
Each mode is driven with aligned and misaligned starts and with several sizes, so that fixed versus incrementing versus wrapping differ in the second beat and alignment shows in the first. Wrapping bursts start at the window base and in its middle, which separates a correct fold point from one computed off the start address. Single-beat and 256-beat bursts bound the length counter, and each burst is repeated under a stalling consumer, which separates holding the beat from advancing on valid alone. Illegal wrapping lengths, misaligned wrapping starts and the reserved code check that rejection yields an error pulse and no beats.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [SW-1:0] cmd_size,
  input  logic [1:0]    cmd_mode,
  output logic          cmd_err,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_addr,
  output logic          beat_last
);
  localparam logic [1:0] M_FIXED = 2'd0;
  localparam logic [1:0] M_INCR  = 2'd1;
  localparam logic [1:0] M_WRAP  = 2'd2;
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic          busy_q, err_q;
  logic [AW-1:0] addr_q, step_q, wmask_q;
  logic [LW-1:0] left_q;
  logic [1:0]    mode_q;

  logic [AW-1:0] c_step, c_total, c_start, nxt_addr;
  logic          c_len_ok, c_bad, take, adv;

  assign c_step   = ONE << cmd_size;
  assign c_total  = (AW'(cmd_len) + ONE) << cmd_size;
  assign c_len_ok = (cmd_len == LW'(1)) || (cmd_len == LW'(3)) ||
                    (cmd_len == LW'(7)) || (cmd_len == LW'(15));
  assign c_bad    = (cmd_mode == 2'd3) ||
                    ((cmd_mode == M_WRAP) && (!c_len_ok || ((cmd_addr & (c_step - ONE)) != '0)));
  assign c_start  = (cmd_mode == M_FIXED) ? cmd_addr : (cmd_addr & ~(c_step - ONE));

  assign cmd_ready  = !busy_q;
  assign take       = cmd_valid && cmd_ready;
  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign beat_last  = busy_q && (left_q == '0);
  assign cmd_err    = err_q;
  assign adv        = beat_valid && beat_ready;

  always_comb begin
    case (mode_q)
      M_INCR:  nxt_addr = addr_q + step_q;
      M_WRAP:  nxt_addr = (addr_q & ~wmask_q) | ((addr_q + step_q) & wmask_q);
      default: nxt_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      step_q  <= '0;
      wmask_q <= '0;
      left_q  <= '0;
      mode_q  <= M_FIXED;
    end else begin
      err_q <= take && c_bad;
      if (take && !c_bad) begin
        busy_q  <= 1'b1;
        addr_q  <= c_start;
        step_q  <= c_step;
        wmask_q <= c_total - ONE;
        left_q  <= cmd_len;
        mode_q  <= cmd_mode;
      end else if (adv) begin
        if (left_q == '0) busy_q <= 1'b0;
        else begin
          left_q <= left_q - LW'(1);
          addr_q <= nxt_addr;
        end
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_last));
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !cmd_ready);
  p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && beat_ready |=> cmd_ready);
  p_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !beat_last && mode_q == M_FIXED |=> beat_addr == $past(beat_addr));
  p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !beat_last && mode_q == M_INCR |=> beat_addr == $past(beat_addr) + step_q);
  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && mode_q != M_FIXED |-> (beat_addr & (step_q - ONE)) == '0);
  p_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !beat_valid);
  p_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, beat_ready = 0;
  logic [31:0] cmd_addr = 0;
  logic [7:0]  cmd_len = 0;
  logic [2:0]  cmd_size = 0;
  logic [1:0]  cmd_mode = 0;
  logic        cmd_ready, cmd_err, beat_valid, beat_last;
  logic [31:0] beat_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_mode(cmd_mode),
    .cmd_err(cmd_err), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_last(beat_last));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input int len, input int sz, input int md,
                     input bit stall, input string tag);
    longint q[$];
    longint step, base, tot, prev;
    bit bad, prev_stall;
    int lim;
    step = longint'(1) << sz;
    bad = (md == 3) || (md == 2 && (!(len == 1 || len == 3 || len == 7 || len == 15) ||
                                    (a % step) != 0));
    for (int i = 0; i <= len; i++) begin
      if (md == 0) q.push_back(a);
      else if (md == 1) q.push_back(a - (a % step) + i * step);
      else begin
        tot = (len + 1) * step;
        base = a - (a % tot);
        q.push_back(base + ((a - base + i * step) % tot));
      end
    end
    @(negedge clk);
    chk(cmd_ready == 1, {tag, " R7 idle before command"}, cmd_ready, 1);
    cmd_addr = a; cmd_len = 8'(len); cmd_size = 3'(sz); cmd_mode = 2'(md); cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (bad) begin
      chk(cmd_err == 1, {tag, " R8 error pulse"}, cmd_err, 1);
      chk(beat_valid == 0, {tag, " R8 no beats"}, beat_valid, 0);
      @(negedge clk);
      chk(cmd_err == 0 && beat_valid == 0 && cmd_ready == 1, {tag, " R8 pulse one cycle"},
          {cmd_err, beat_valid, cmd_ready}, 3'b001);
      return;
    end
    chk(cmd_err == 0, {tag, " R8 no error on legal command"}, cmd_err, 0);
    prev_stall = 0; prev = 0; lim = 0;
    while (q.size() > 0 && lim < 2000) begin
      bit r;
      lim++;
      chk(beat_valid == 1, {tag, " R5 beat present"}, beat_valid, 1);
      chk(beat_addr == q[0][31:0], {tag, md == 0 ? " R2 addr" : md == 1 ? " R3 addr" : " R4 addr"},
          beat_addr, q[0]);
      chk(beat_last == (q.size() == 1), {tag, " R5 last flag"}, beat_last, q.size() == 1);
      chk(cmd_ready == 0, {tag, " R7 busy"}, cmd_ready, 0);
      if (prev_stall) chk(beat_addr == prev[31:0], {tag, " R6 hold"}, beat_addr, prev);
      r = !stall || (cyc % 3 == 0);
      beat_ready = r;
      prev = beat_addr; prev_stall = !r;
      @(negedge clk);
      if (r) void'(q.pop_front());
    end
    beat_ready = 0;
    chk(beat_valid == 0 && cmd_ready == 1, {tag, " R7 free after last R5 count"},
        {beat_valid, cmd_ready}, 2'b01);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk(cmd_ready == 1 && beat_valid == 0 && cmd_err == 0, "R1 reset state",
        {cmd_ready, beat_valid, cmd_err}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(cmd_ready == 1 && beat_valid == 0 && cmd_err == 0, "R1 after reset",
        {cmd_ready, beat_valid, cmd_err}, 3'b100);
    for (int s = 0; s < 2; s++) begin
      run(32'h1003, 3, 2, 0, s[0], "fixed misaligned");
      run(32'h1000, 3, 2, 1, s[0], "incr aligned");
      run(32'h1003, 3, 3, 1, s[0], "incr misaligned");
      run(32'h100, 3, 2, 2, s[0], "wrap base");
      run(32'h108, 3, 2, 2, s[0], "wrap mid");
      run(32'h2038, 7, 3, 2, s[0], "wrap 8x8");
      run(32'h3004, 15, 1, 2, s[0], "wrap 16x2");
      run(32'h40, 0, 0, 1, s[0], "single beat");
    end
    run(32'h8000, 255, 2, 1, 0, "incr 256");
    run(32'h8000, 255, 0, 0, 1, "fixed 256");
    run(32'h100, 2, 2, 2, 0, "wrap len3");
    run(32'h102, 3, 2, 2, 0, "wrap misaligned");
    run(32'h100, 3, 2, 3, 0, "reserved mode");
    run(32'h200, 1, 2, 2, 1, "wrap 2 after errors");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule